// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block caches 64 virtual-to-physical page mappings, each covering one 4 KB page. Any mapping can sit in any of the 64 slots. A lookup port takes a virtual page number and the current address-space identifier (ASID). In the same cycle it returns the physical page number, four attribute flags, a hit indication and a multiple-match fault. The cached mappings are managed through three staging registers: an entry-high register (virtual page and ASID), an entry-low register (physical page and flags) and a slot register (slot number plus a probe-failure flag). A fourth register, the victim register, supplies a free-running slot number.

A two-bit command port starts one of four operations. These are: search for the entry-high contents, copy a slot into the staging registers, write the staging registers into the slot named by the slot register, and write them into the slot named by the victim register. The valid flag is reported but plays no part in matching. An entry marked global matches under any ASID.

Software must never leave two entries that can match the same lookup. If a lookup request or a search finds two or more matches, the unit latches a shutdown state, and only the asynchronous reset clears it. The entry storage is not cleared by reset, so it must be filled with distinct virtual pages before any lookup or search is made.

Top module: `tlb_xlate`

## Requirements
- R1: A write command (cmd_op 2) stores the entry-high and entry-low registers into the slot held in tlb_index bits 13:8. A read command (cmd_op 1) loads that slot into tlb_hi/tlb_lo on the next cycle. Layout of tlb_hi: virtual page in bits 31:12, ASID in bits 11:6. Layout of tlb_lo: physical page in bits 31:12, then flags N, D, V, G in bits 11, 10, 9, 8. All other bits of both read as 0.
- R2: An entry matches a lookup when its virtual page equals lk_vpn and either its G flag is set or its ASID equals lk_asid. With lk_req high and exactly one match, lk_hit is 1 in the same cycle, with that entry's physical page on lk_ppn and its flags on lk_flags as {N,D,V,G}. With no match, lk_hit is 0.
- R3: The V flag is not part of matching. A matching entry with V clear gives lk_hit 1 and lk_flags bit 1 equal to 0.
- R4: A search command (cmd_op 0) compares the entry-high register against all slots. On a single hit, the next cycle shows tlb_index bit 31 at 0 and the hit slot in bits 13:8. On a miss, bit 31 becomes 1 and bits 13:8 keep their value.
- R5: tlb_random shows a slot number in bits 13:8. It is 63 after reset and decreases by one every cycle. The cycle after it shows 8, it shows 63 again, so it never shows a value below 8.
- R6: A victim write command (cmd_op 3) stores the staging registers into the slot that tlb_random shows in the cycle the command is given.
- R7: With lk_req high and two or more matches, lk_multi is 1 in the same cycle. A lookup multi-match, or a search that finds two or more matches, sets shutdown on the next cycle. shutdown then stays set until rst_n is asserted.
- R8: While shutdown is set, lk_hit is 0 and commands change neither the entries nor the staging and slot registers.
- R9: Reset clears tlb_hi, tlb_lo, tlb_index and shutdown, and sets tlb_random to 63. Entry contents written before reset survive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Starts the command on cmd_op this cycle |
| cmd_op | input | 2 | 0 search, 1 read slot, 2 write slot, 3 write victim |
| hi_wr_en | input | 1 | Load entry-high register |
| hi_wr_data | input | 32 | Entry-high write value |
| lo_wr_en | input | 1 | Load entry-low register |
| lo_wr_data | input | 32 | Entry-low write value |
| idx_wr_en | input | 1 | Load slot register |
| idx_wr_data | input | 32 | Slot register write value (bit 31 fail flag, bits 13:8 slot) |
| tlb_hi | output | 32 | Entry-high register |
| tlb_lo | output | 32 | Entry-low register |
| tlb_index | output | 32 | Slot register |
| tlb_random | output | 32 | Victim slot register |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 6 | Current ASID |
| lk_hit | output | 1 | Lookup matched |
| lk_ppn | output | 20 | Physical page of the matching entry |
| lk_flags | output | 4 | {N,D,V,G} of the matching entry |
| lk_multi | output | 1 | Two or more entries matched the lookup |
| shutdown | output | 1 | Latched fatal multiple-match state |

## Verification
The bench holds two entries with the same virtual page but different non-global ASIDs. A design that ignored the ASID would report a multi-match there. It also places a global entry looked up under an unrelated ASID, which a design that skipped the G bypass would miss. An entry with V clear is looked up and must report a hit, so a design that filtered on V would show a miss. A search miss must leave the slot field untouched, and a design that cleared it would show slot 0. The victim counter is followed through its wrap from 8 to 63, which catches off-by-one floors. The bench then forces a duplicate mapping. It checks that shutdown latches and blocks later writes, and that reset clears shutdown while the entries survive.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int REG_W      = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int VPN_W      = REG_W - PAGE_SHIFT;
    localparam int PPN_W      = REG_W - PAGE_SHIFT;
    localparam int ASID_W     = 6;
    localparam int ASID_LSB   = 6;
    localparam int FLAG_W     = 4;
    localparam int FLAG_LSB   = 8;
    localparam int SLOT_LSB   = 8;
    localparam int FAIL_BIT   = 31;

    typedef struct packed {
        logic nc;
        logic dirty;
        logic valid;
        logic glob;
    } tlb_flags_t;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        tlb_flags_t        flags;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        OP_PROBE      = 2'd0,
        OP_READ       = 2'd1,
        OP_WRITE_IDX  = 2'd2,
        OP_WRITE_RAND = 2'd3
    } tlb_op_e;

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    localparam int SLOT_W = $clog2(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SLOT_W-1:0]      wr_slot,
    input  tlb_entry_t             wr_entry,
    input  logic [VPN_W-1:0]       pa_vpn,
    input  logic [ASID_W-1:0]      pa_asid,
    output logic [NUM_ENTRIES-1:0] pa_match,
    input  logic [VPN_W-1:0]       pb_vpn,
    input  logic [ASID_W-1:0]      pb_asid,
    output logic [NUM_ENTRIES-1:0] pb_match,
    input  logic [SLOT_W-1:0]      rd_slot,
    output tlb_entry_t             rd_entry,
    input  logic [SLOT_W-1:0]      sel_slot,
    output logic [PPN_W-1:0]       sel_ppn,
    output tlb_flags_t             sel_flags
);

    tlb_entry_t             ent_view [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] wr_hot;
    tlb_entry_t             sel_entry;

    // Storage has no reset: contents are undefined until software loads them.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        tlb_entry_t entry_d;
        tlb_entry_t entry_q;

        assign wr_hot[g] = wr_en && (wr_slot == SLOT_W'(g));

        always_comb begin
            entry_d = entry_q;
            if (wr_hot[g]) begin
                entry_d = wr_entry;
            end
        end

        always_ff @(posedge clk) begin
            entry_q <= entry_d;
        end

        assign ent_view[g] = entry_q;

        // Valid flag is deliberately absent from the compare.
        assign pa_match[g] = (entry_q.vpn == pa_vpn) &&
                             (entry_q.flags.glob || (entry_q.asid == pa_asid));
        assign pb_match[g] = (entry_q.vpn == pb_vpn) &&
                             (entry_q.flags.glob || (entry_q.asid == pb_asid));
    end

    assign rd_entry  = ent_view[rd_slot];
    assign sel_entry = ent_view[sel_slot];
    assign sel_ppn   = sel_entry.ppn;
    assign sel_flags = sel_entry.flags;

    logic unused_sel;
    assign unused_sel = ^{sel_entry.vpn, sel_entry.asid};

    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hot)) else $error("more than one slot written");  // R1

endmodule

// File: rtl/tlb_match_enc.sv
module tlb_match_enc #(
    parameter int NUM_ENTRIES = 64,
    localparam int SLOT_W = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] match,
    output logic                   any,
    output logic                   multi,
    output logic [SLOT_W-1:0]      slot
);

    always_comb begin
        slot = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                slot = SLOT_W'(i);
            end
        end
    end

    assign any   = |match;
    // Clearing the lowest set bit leaves something only when two or more were set.
    assign multi = |(match & (match - NUM_ENTRIES'(1)));

endmodule

// File: rtl/tlb_rand.sv
module tlb_rand #(
    parameter int NUM_ENTRIES = 64,
    parameter int RAND_FLOOR  = 8,
    localparam int SLOT_W = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot
);

    localparam logic [SLOT_W-1:0] TOP_S   = SLOT_W'(NUM_ENTRIES - 1);
    localparam logic [SLOT_W-1:0] FLOOR_S = SLOT_W'(RAND_FLOOR);

    logic [SLOT_W-1:0] slot_d;
    logic [SLOT_W-1:0] slot_q;

    always_comb begin
        if (slot_q == FLOOR_S) begin
            slot_d = TOP_S;
        end else begin
            slot_d = slot_q - SLOT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= TOP_S;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign slot = slot_q;

    AST_RAND_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q >= FLOOR_S) else $error("victim below floor");  // R5
    AST_RAND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q != FLOOR_S) |=> (slot_q == $past(slot_q) - SLOT_W'(1))) else $error("victim step");  // R5
    AST_RAND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == FLOOR_S) |=> (slot_q == TOP_S)) else $error("victim wrap");  // R5

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    parameter int RAND_FLOOR  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              hi_wr_en,
    input  logic [REG_W-1:0]  hi_wr_data,
    input  logic              lo_wr_en,
    input  logic [REG_W-1:0]  lo_wr_data,
    input  logic              idx_wr_en,
    input  logic [REG_W-1:0]  idx_wr_data,
    output logic [REG_W-1:0]  tlb_hi,
    output logic [REG_W-1:0]  tlb_lo,
    output logic [REG_W-1:0]  tlb_index,
    output logic [REG_W-1:0]  tlb_random,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [FLAG_W-1:0] lk_flags,
    output logic              lk_multi,
    output logic              shutdown
);

    localparam int SLOT_W  = $clog2(NUM_ENTRIES);
    localparam int PAD_IDX = REG_W - 1 - SLOT_W - SLOT_LSB;
    localparam int PAD_RND = REG_W - SLOT_W - SLOT_LSB;

    typedef struct packed {
        logic [VPN_W-1:0]  hi_vpn;
        logic [ASID_W-1:0] hi_asid;
        logic [PPN_W-1:0]  lo_ppn;
        tlb_flags_t        lo_flags;
        logic [SLOT_W-1:0] idx_slot;
        logic              idx_fail;
        logic              shut;
    } state_t;

    state_t st_d;
    state_t st_q;

    tlb_op_e op;
    assign op = tlb_op_e'(cmd_op);

    logic                   wr_en_c;
    logic [SLOT_W-1:0]      wr_slot_c;
    tlb_entry_t             wr_entry_c;
    logic [SLOT_W-1:0]      rand_slot;
    logic [NUM_ENTRIES-1:0] pr_match;
    logic [NUM_ENTRIES-1:0] lk_match;
    logic                   pr_any, pr_multi, lk_any, lk_multi_raw;
    logic [SLOT_W-1:0]      pr_slot, lk_slot;
    tlb_entry_t             rd_entry;
    logic [PPN_W-1:0]       sel_ppn;
    tlb_flags_t             sel_flags;

    // Victim slot counter
    tlb_rand #(.NUM_ENTRIES(NUM_ENTRIES), .RAND_FLOOR(RAND_FLOOR)) u_rand (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (rand_slot)
    );

    // Entry writes: blocked while shut down
    assign wr_en_c   = cmd_valid && !st_q.shut &&
                       ((op == OP_WRITE_IDX) || (op == OP_WRITE_RAND));
    assign wr_slot_c = (op == OP_WRITE_RAND) ? rand_slot : st_q.idx_slot;
    assign wr_entry_c = '{vpn: st_q.hi_vpn, asid: st_q.hi_asid,
                          ppn: st_q.lo_ppn, flags: st_q.lo_flags};

    tlb_cam #(.NUM_ENTRIES(NUM_ENTRIES)) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en_c),
        .wr_slot   (wr_slot_c),
        .wr_entry  (wr_entry_c),
        .pa_vpn    (st_q.hi_vpn),
        .pa_asid   (st_q.hi_asid),
        .pa_match  (pr_match),
        .pb_vpn    (lk_vpn),
        .pb_asid   (lk_asid),
        .pb_match  (lk_match),
        .rd_slot   (st_q.idx_slot),
        .rd_entry  (rd_entry),
        .sel_slot  (lk_slot),
        .sel_ppn   (sel_ppn),
        .sel_flags (sel_flags)
    );

    tlb_match_enc #(.NUM_ENTRIES(NUM_ENTRIES)) u_enc_probe (
        .match (pr_match),
        .any   (pr_any),
        .multi (pr_multi),
        .slot  (pr_slot)
    );

    tlb_match_enc #(.NUM_ENTRIES(NUM_ENTRIES)) u_enc_lookup (
        .match (lk_match),
        .any   (lk_any),
        .multi (lk_multi_raw),
        .slot  (lk_slot)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;

        if (hi_wr_en) begin
            st_d.hi_vpn  = hi_wr_data[REG_W-1:PAGE_SHIFT];
            st_d.hi_asid = hi_wr_data[ASID_LSB +: ASID_W];
        end
        if (lo_wr_en) begin
            st_d.lo_ppn   = lo_wr_data[REG_W-1:PAGE_SHIFT];
            st_d.lo_flags = tlb_flags_t'(lo_wr_data[FLAG_LSB +: FLAG_W]);
        end
        if (idx_wr_en) begin
            st_d.idx_slot = idx_wr_data[SLOT_LSB +: SLOT_W];
            st_d.idx_fail = idx_wr_data[FAIL_BIT];
        end

        if (cmd_valid && !st_q.shut) begin
            case (op)
                OP_PROBE: begin
                    if (pr_multi) begin
                        st_d.shut = 1'b1;
                    end else if (pr_any) begin
                        st_d.idx_slot = pr_slot;
                        st_d.idx_fail = 1'b0;
                    end else begin
                        st_d.idx_fail = 1'b1;
                    end
                end
                OP_READ: begin
                    st_d.hi_vpn   = rd_entry.vpn;
                    st_d.hi_asid  = rd_entry.asid;
                    st_d.lo_ppn   = rd_entry.ppn;
                    st_d.lo_flags = rd_entry.flags;
                end
                default: ;
            endcase
        end

        if (lk_multi) begin
            st_d.shut = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Register views and lookup outputs
    assign tlb_hi     = {st_q.hi_vpn, st_q.hi_asid, {ASID_LSB{1'b0}}};
    assign tlb_lo     = {st_q.lo_ppn, st_q.lo_flags, {FLAG_LSB{1'b0}}};
    assign tlb_index  = {st_q.idx_fail, {PAD_IDX{1'b0}}, st_q.idx_slot, {SLOT_LSB{1'b0}}};
    assign tlb_random = {{PAD_RND{1'b0}}, rand_slot, {SLOT_LSB{1'b0}}};

    assign lk_hit   = lk_req && lk_any && !st_q.shut;
    assign lk_multi = lk_req && lk_multi_raw;
    assign lk_ppn   = sel_ppn;
    assign lk_flags = sel_flags;
    assign shutdown = st_q.shut;

    logic unused_bits;
    assign unused_bits = ^{hi_wr_data[ASID_LSB-1:0], lo_wr_data[FLAG_LSB-1:0],
                           idx_wr_data[FAIL_BIT-1:SLOT_LSB+SLOT_W],
                           idx_wr_data[SLOT_LSB-1:0]};

    AST_SHUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> shutdown) else $error("shutdown released");  // R7
    AST_MULTI_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |=> shutdown) else $error("multi-match did not shut down");  // R7
    AST_SHUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && cmd_valid && (op == OP_READ) && !hi_wr_en && !lo_wr_en)
        |=> ($stable(tlb_hi) && $stable(tlb_lo))) else $error("read during shutdown");  // R8
    AST_PROBE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (op == OP_PROBE) && !shutdown && !pr_any && !idx_wr_en)
        |=> (tlb_index[FAIL_BIT] && $stable(tlb_index[SLOT_LSB +: SLOT_W]))) else $error("probe miss");  // R4
    AST_PROBE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (op == OP_PROBE) && !shutdown && pr_any && !pr_multi && !idx_wr_en)
        |=> !tlb_index[FAIL_BIT]) else $error("probe hit");  // R4

endmodule

// File: tb/tb_tlb_xlate.sv
module tb_tlb_xlate;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic        hi_wr_en, lo_wr_en, idx_wr_en;
    logic [31:0] hi_wr_data, lo_wr_data, idx_wr_data;
    logic [31:0] tlb_hi, tlb_lo, tlb_index, tlb_random;
    logic        lk_req;
    logic [19:0] lk_vpn;
    logic [5:0]  lk_asid;
    logic        lk_hit, lk_multi, shutdown;
    logic [19:0] lk_ppn;
    logic [3:0]  lk_flags;

    always #10 clk = ~clk;

    tlb_xlate dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data),
        .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data),
        .idx_wr_en(idx_wr_en), .idx_wr_data(idx_wr_data),
        .tlb_hi(tlb_hi), .tlb_lo(tlb_lo), .tlb_index(tlb_index), .tlb_random(tlb_random),
        .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_flags(lk_flags),
        .lk_multi(lk_multi), .shutdown(shutdown)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Behavioural reference state
    int unsigned m_vpn [64];
    int unsigned m_asid[64];
    int unsigned m_ppn [64];
    int unsigned m_fl  [64];
    int unsigned m_hi_vpn, m_hi_asid, m_lo_ppn, m_lo_fl, m_slot, m_fail, m_rand, m_shut;

    task automatic check(input string tag, input int unsigned act, input int unsigned exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int unsigned mk_hi(input int unsigned vpn, input int unsigned asid);
        return (vpn << 12) | (asid << 6);
    endfunction

    function automatic int unsigned mk_lo(input int unsigned ppn, input int unsigned fl);
        return (ppn << 12) | (fl << 8);
    endfunction

    function automatic void m_find(input int unsigned vpn, input int unsigned asid,
                                   output int cnt, output int slot);
        cnt = 0;
        slot = 0;
        for (int i = 63; i >= 0; i--) begin
            if (m_vpn[i] == vpn && (((m_fl[i] & 1) != 0) || m_asid[i] == asid)) begin
                cnt++;
                slot = i;
            end
        end
    endfunction

    task automatic m_reset();
        m_hi_vpn = 0; m_hi_asid = 0; m_lo_ppn = 0; m_lo_fl = 0;
        m_slot = 0; m_fail = 0; m_rand = 63; m_shut = 0;
    endtask

    task automatic compare_all();
        int cnt, s;
        bit exp_hit;
        check("R1 tlb_hi", tlb_hi, mk_hi(m_hi_vpn, m_hi_asid));
        check("R1 tlb_lo", tlb_lo, mk_lo(m_lo_ppn, m_lo_fl));
        check("R4 tlb_index", tlb_index, (m_fail << 31) | (m_slot << 8));
        check("R5 tlb_random", tlb_random, m_rand << 8);
        check("R7 shutdown", shutdown, m_shut);
        m_find(lk_vpn, lk_asid, cnt, s);
        exp_hit = lk_req && cnt >= 1 && m_shut == 0;
        check("R2 lk_hit", lk_hit, exp_hit);
        check("R7 lk_multi", lk_multi, (lk_req && cnt > 1) ? 1 : 0);
        if (exp_hit && cnt == 1) begin
            check("R2 lk_ppn", lk_ppn, m_ppn[s]);
            check("R2 lk_flags", lk_flags, m_fl[s]);
        end
    endtask

    task automatic model_update();
        int cnt, s;
        int unsigned n_hi_vpn, n_hi_asid, n_lo_ppn, n_lo_fl, n_slot, n_fail, n_shut;
        int unsigned wslot;
        bit wr;
        if (!rst_n) begin
            m_reset();
            return;
        end
        n_hi_vpn = m_hi_vpn; n_hi_asid = m_hi_asid; n_lo_ppn = m_lo_ppn; n_lo_fl = m_lo_fl;
        n_slot = m_slot; n_fail = m_fail; n_shut = m_shut;
        wr = 0; wslot = 0;
        if (hi_wr_en) begin n_hi_vpn = hi_wr_data >> 12; n_hi_asid = (hi_wr_data >> 6) & 63; end
        if (lo_wr_en) begin n_lo_ppn = lo_wr_data >> 12; n_lo_fl = (lo_wr_data >> 8) & 15; end
        if (idx_wr_en) begin n_slot = (idx_wr_data >> 8) & 63; n_fail = idx_wr_data >> 31; end
        if (cmd_valid && m_shut == 0) begin
            case (cmd_op)
                2'd0: begin
                    m_find(m_hi_vpn, m_hi_asid, cnt, s);
                    if (cnt > 1) n_shut = 1;
                    else if (cnt == 1) begin n_slot = s; n_fail = 0; end
                    else n_fail = 1;
                end
                2'd1: begin
                    n_hi_vpn = m_vpn[m_slot]; n_hi_asid = m_asid[m_slot];
                    n_lo_ppn = m_ppn[m_slot]; n_lo_fl = m_fl[m_slot];
                end
                2'd2: begin wr = 1; wslot = m_slot; end
                default: begin wr = 1; wslot = m_rand; end
            endcase
        end
        if (lk_req) begin
            m_find(lk_vpn, lk_asid, cnt, s);
            if (cnt > 1) n_shut = 1;
        end
        if (wr) begin
            m_vpn[wslot] = m_hi_vpn; m_asid[wslot] = m_hi_asid;
            m_ppn[wslot] = m_lo_ppn; m_fl[wslot] = m_lo_fl;
        end
        m_rand = (m_rand == 8) ? 63 : m_rand - 1;
        m_hi_vpn = n_hi_vpn; m_hi_asid = n_hi_asid; m_lo_ppn = n_lo_ppn; m_lo_fl = n_lo_fl;
        m_slot = n_slot; m_fail = n_fail; m_shut = n_shut;
    endtask

    // Called at a falling edge with inputs set; returns at the next falling edge.
    task automatic tick();
        #5;
        compare_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic load_regs(input bit we_hi, input int unsigned hi,
                             input bit we_lo, input int unsigned lo,
                             input bit we_idx, input int unsigned idx);
        hi_wr_en = we_hi; hi_wr_data = hi;
        lo_wr_en = we_lo; lo_wr_data = lo;
        idx_wr_en = we_idx; idx_wr_data = idx;
        tick();
        hi_wr_en = 0; lo_wr_en = 0; idx_wr_en = 0;
    endtask

    task automatic do_cmd(input logic [1:0] op);
        cmd_valid = 1; cmd_op = op;
        tick();
        cmd_valid = 0;
    endtask

    task automatic put_entry(input int slot, input int unsigned vpn, input int unsigned asid,
                             input int unsigned ppn, input int unsigned fl);
        load_regs(1, mk_hi(vpn, asid), 1, mk_lo(ppn, fl), 1, slot << 8);
        do_cmd(2'd2);
    endtask

    task automatic set_lookup(input int unsigned vpn, input int unsigned asid);
        lk_req = 1; lk_vpn = 20'(vpn); lk_asid = 6'(asid);
        #2;
    endtask

    task automatic end_lookup();
        tick();
        lk_req = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int unsigned rs;
        rst_n = 0; cmd_valid = 0; cmd_op = 0;
        hi_wr_en = 0; lo_wr_en = 0; idx_wr_en = 0;
        hi_wr_data = 0; lo_wr_data = 0; idx_wr_data = 0;
        lk_req = 0; lk_vpn = 0; lk_asid = 0;
        m_reset();
        @(negedge clk);
        tick();
        tick();
        rst_n = 1;
        // R9: reset state
        check("R9 index after reset", tlb_index, 0);
        check("R9 random after reset", tlb_random, 63 << 8);
        check("R9 shutdown after reset", shutdown, 0);
        tick();

        // Fill every slot with a distinct page from an unused region
        for (int i = 0; i < 64; i++) begin
            put_entry(i, 32'h80000 | i, 0, i, 0);
        end

        put_entry(10, 20'h00400, 5, 20'h12345, 4'b0110);
        put_entry(11, 20'h00401, 5, 20'h0AAAA, 4'b0000);
        put_entry(12, 20'h7FFFF, 9, 20'hFFFFF, 4'b1011);
        put_entry(13, 20'h00400, 6, 20'h22222, 4'b0010);

        // R2: ASID-qualified hit
        set_lookup(20'h00400, 5);
        check("R2 hit asid 5", lk_hit, 1);
        check("R2 ppn asid 5", lk_ppn, 20'h12345);
        end_lookup();
        set_lookup(20'h00400, 6);
        check("R2 ppn asid 6", lk_ppn, 20'h22222);
        check("R2 no multi on distinct asid", lk_multi, 0);
        end_lookup();
        set_lookup(20'h00400, 7);
        check("R2 miss wrong asid", lk_hit, 0);
        end_lookup();
        // R3: valid clear still hits
        set_lookup(20'h00401, 5);
        check("R3 hit with V clear", lk_hit, 1);
        check("R3 V flag clear", lk_flags[1], 0);
        end_lookup();
        // R2: global ignores asid
        set_lookup(20'h7FFFF, 33);
        check("R2 global hit", lk_hit, 1);
        check("R2 global flags", lk_flags, 4'b1011);
        end_lookup();
        set_lookup(20'h12345, 5);
        check("R2 miss unknown page", lk_hit, 0);
        end_lookup();

        // R4: probe hit then miss
        load_regs(1, mk_hi(20'h00400, 6), 0, 0, 0, 0);
        do_cmd(2'd0);
        check("R4 probe hit", tlb_index, 13 << 8);
        load_regs(1, mk_hi(20'h00999, 1), 0, 0, 0, 0);
        do_cmd(2'd0);
        check("R4 probe miss keeps slot", tlb_index, (32'h1 << 31) | (13 << 8));

        // R1: read back by slot
        load_regs(0, 0, 0, 0, 1, 12 << 8);
        do_cmd(2'd1);
        check("R1 read lo", tlb_lo, mk_lo(20'hFFFFF, 4'b1011));
        check("R1 read hi", tlb_hi, mk_hi(20'h7FFFF, 9));

        // R6: write to victim slot
        load_regs(1, mk_hi(20'h55555, 3), 1, mk_lo(20'h31337, 4'b0110), 0, 0);
        while (m_rand != 40) tick();
        rs = m_rand;
        do_cmd(2'd3);
        do_cmd(2'd0);
        check("R6 victim slot", tlb_index, rs << 8);

        // R5: wrap from floor
        while (m_rand != 8) tick();
        check("R5 at floor", tlb_random, 8 << 8);
        tick();
        check("R5 wrap to top", tlb_random, 63 << 8);
        repeat (70) tick();

        // R7: duplicate mapping trips shutdown
        put_entry(20, 20'h00400, 5, 20'h0BEEF, 4'b0010);
        set_lookup(20'h00400, 5);
        check("R7 multi flagged", lk_multi, 1);
        end_lookup();
        check("R7 shutdown latched", shutdown, 1);
        repeat (3) tick();
        check("R7 shutdown sticky", shutdown, 1);

        // R8: frozen while shut down
        put_entry(21, 20'h00600, 5, 20'h06060, 4'b0010);
        set_lookup(20'h00400, 6);
        check("R8 no hit while shut down", lk_hit, 0);
        end_lookup();
        load_regs(0, 0, 0, 0, 1, 10 << 8);
        do_cmd(2'd1);
        check("R8 read ignored", tlb_hi, mk_hi(20'h00600, 5));

        // R9: reset clears state, keeps entries
        rst_n = 0;
        m_reset();
        tick();
        tick();
        rst_n = 1;
        check("R9 shutdown cleared", shutdown, 0);
        check("R9 hi cleared", tlb_hi, 0);
        tick();
        set_lookup(20'h7FFFF, 1);
        check("R9 entry survives reset", lk_ppn, 20'hFFFFF);
        check("R9 hit after reset", lk_hit, 1);
        end_lookup();
        set_lookup(20'h00600, 5);
        check("R8 write during shutdown dropped", lk_hit, 0);
        end_lookup();
        tick();

        finish_run();
    end

endmodule